// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Aggregator

This block gathers a wide set of peripheral interrupt sources into a single request line for a processor. Sources come in two banks. The first bank feeds a 32-bit top-level status word directly. The second bank feeds a 32-bit secondary status word. The secondary word has its own enable mask, and three group summaries of its enabled bits are folded into three bits of the top-level word. Some top-level positions latch on a rising edge and some follow their input level. Three positions are software-raised. The request line is the OR of the top-level status bits whose top-level mask bit is set.

Software uses a small register port with one address per 32-bit register. Writes take effect in one cycle. Reads are combinational from the address. Latched edge bits are cleared by writing zero to their position. Status reads always show the unmasked state. Raw sources pass through a two-flop synchroniser before they are used.

Top module: `irq_cascade`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low: top status (address 0), top mask (1), edge-latch (2), software (3), secondary status (4) and secondary mask (5).
- R2: A top-level level bit (any of 0–3, 7–15, 20, 21, 25–27, 31) follows `top_src`. It shows in the status word at address 0 two clock edges after the input changes.
- R3: Top-level positions 16–19 and 22–24 set on a rising edge of their synchronised `top_src` bit. They stay set after the source falls. They read at address 0 and at address 2.
- R4: A write to address 2 clears each latched bit whose written data bit is 0. A written 1 leaves that bit unchanged.
- R5: If a new rising edge arrives in the same cycle as a clearing write to address 2, the bit stays set.
- R6: Address 3 stores software bits at positions 28–30. A 0-to-1 change of one of these bits latches the matching top-level bit one edge after the register updates. That bit is cleared through address 2. `top_src` bits 28–30 have no effect.
- R7: Top-level bit 6 is the OR of enabled secondary bits 0–7. Bit 5 is the OR of enabled secondary bits 8–15. Bit 4 is the OR of enabled secondary bits 16–31. `top_src` bits 4–6 have no effect.
- R8: A secondary source counts in its group summary only when its bit in the secondary mask (address 5) is 1. The secondary status read at address 4 is unmasked.
- R9: Secondary positions 16, 22 and 28 latch on a rising edge. A write to address 4 clears each of them whose data bit is 0, and a written 1 keeps it. All other secondary bits follow their level.
- R10: `irq_o` is high exactly when some top-level status bit has its mask bit (address 1) set. The status read at address 0 is unmasked.
- R11: Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| top_src | input | 32 | Raw top-level sources |
| sec_src | input | 32 | Raw secondary sources |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Level results are due two edges after a source changes, because of the synchroniser. Latched edge bits are due three edges after the source changes, because edge detection adds one more edge. A software bit latches one edge after its register write lands. The bench drives and samples on falling edges. It waits four edges after any source change before it reads, so every result has settled. The collision check for R5 is the one exception: the clearing write is placed on the exact edge where the latch captures the rising edge.

// File: rtl/irq_cascade.sv
module irq_cascade #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   top_src,
  input  logic [31:0]   sec_src,
  output logic          irq_o
);
  localparam logic [31:0] EXT_EDGE = 32'h01CF_0000;
  localparam logic [31:0] SW_BITS  = 32'h7000_0000;
  localparam logic [31:0] GRP_BITS = 32'h0000_0070;
  localparam logic [31:0] SEC_EDGE = 32'h1041_0000;
  localparam logic [AW-1:0] A_STAT = 0, A_MASK = 1, A_HARD = 2, A_SOFT = 3,
                            A_SSTAT = 4, A_SMASK = 5;

  logic [31:0] top_s1, top_s2, top_s3, sec_s1, sec_s2, sec_s3;
  logic [31:0] mask_q, hard_q, sec_hard_q, sec_mask_q;
  logic [2:0]  soft_q, soft_d;
  logic [31:0] status, sec_stat, sec_en, ext_rise, sw_rise, sec_rise;
  logic [2:0]  grp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_s1 <= '0; top_s2 <= '0; top_s3 <= '0;
      sec_s1 <= '0; sec_s2 <= '0; sec_s3 <= '0;
      soft_d <= '0;
    end else begin
      top_s1 <= top_src; top_s2 <= top_s1; top_s3 <= top_s2;
      sec_s1 <= sec_src; sec_s2 <= sec_s1; sec_s3 <= sec_s2;
      soft_d <= soft_q;
    end
  end

  assign ext_rise = top_s2 & ~top_s3 & EXT_EDGE;
  assign sw_rise  = {1'b0, soft_q & ~soft_d, 28'b0};
  assign sec_rise = sec_s2 & ~sec_s3 & SEC_EDGE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      hard_q     <= '0;
      soft_q     <= '0;
      sec_hard_q <= '0;
      sec_mask_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_MASK)  mask_q     <= reg_wdata;
      if (reg_we && reg_addr == A_SOFT)  soft_q     <= reg_wdata[30:28];
      if (reg_we && reg_addr == A_SMASK) sec_mask_q <= reg_wdata;
      hard_q <= ((reg_we && reg_addr == A_HARD) ? (hard_q & reg_wdata) : hard_q)
                | ext_rise | sw_rise;
      sec_hard_q <= ((reg_we && reg_addr == A_SSTAT) ? (sec_hard_q & reg_wdata) : sec_hard_q)
                    | sec_rise;
    end
  end

  assign sec_stat = (sec_s2 & ~SEC_EDGE) | sec_hard_q;
  assign sec_en   = sec_stat & sec_mask_q;
  assign grp      = {|sec_en[7:0], |sec_en[15:8], |sec_en[31:16]};
  assign status   = (top_s2 & ~(EXT_EDGE | SW_BITS | GRP_BITS)) | hard_q
                    | {25'b0, grp, 4'b0};
  assign irq_o    = |(status & mask_q);

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status;
      A_MASK:  reg_rdata = mask_q;
      A_HARD:  reg_rdata = hard_q;
      A_SOFT:  reg_rdata = {1'b0, soft_q, 28'b0};
      A_SSTAT: reg_rdata = sec_stat;
      A_SMASK: reg_rdata = sec_mask_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module irq_cascade_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          irq_o,
  input logic [31:0]   hard_q,
  input logic [31:0]   sec_hard_q,
  input logic [31:0]   sec_mask_q,
  input logic [31:0]   status,
  input logic [2:0]    soft_q
);
  // R1
  always @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (!irq_o);

  // R4
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd2) |=> ((hard_q & $past(hard_q)) == $past(hard_q)));

  // R9
  sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd4) |=> ((sec_hard_q & $past(sec_hard_q)) == $past(sec_hard_q)));

  // R8
  sec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_mask_q == 32'h0) |-> (status[6:4] == 3'b000));

  // R6
  soft_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3 && reg_wdata[28] && !soft_q[0]) |-> ##2 hard_q[28]);

  // R10
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && reg_wdata == 32'h0) |=> !irq_o);
endmodule

bind irq_cascade irq_cascade_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .hard_q(hard_q),
  .sec_hard_q(sec_hard_q), .sec_mask_q(sec_mask_q), .status(status),
  .soft_q(soft_q)
);

// File: tb/irq_cascade_tb.sv
`timescale 1ns/1ps
module irq_cascade_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, top_src = '0, sec_src = '0, rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_cascade dut_i (.clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .top_src(top_src), .sec_src(sec_src),
    .irq_o(irq));

  localparam int N = 6;
  localparam logic [31:0] V_TOP  [N] = '{32'h0000_0101, 32'h0000_0100, 32'h0, 32'h0, 32'h7000_0070, 32'h0020_0000};
  localparam logic [31:0] V_SEC  [N] = '{32'h0, 32'h0, 32'h0000_0003, 32'h0000_0200, 32'h8000_0000, 32'h0};
  localparam logic [31:0] V_TM   [N] = '{32'h1, 32'h1, 32'h40, 32'h40, 32'h10, 32'hFFFF_FFFF};
  localparam logic [31:0] V_SM   [N] = '{32'h0, 32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0};
  localparam logic [31:0] V_STAT [N] = '{32'h0000_0101, 32'h0000_0100, 32'h40, 32'h20, 32'h10, 32'h0020_0000};
  localparam logic       V_IRQ  [N] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] exp, input string req);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq_o: actual %b expected %b", req, irq, exp);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) chk_reg(3'(a), 32'h0, "R1");
    chk_irq(1'b0, "R1");

    // R2 R7 R8 R10 table walk
    for (int k = 0; k < N; k++) begin
      wr(3'd1, V_TM[k]);
      wr(3'd5, V_SM[k]);
      @(negedge clk); top_src = V_TOP[k]; sec_src = V_SEC[k];
      wait_n(4);
      chk_reg(3'd0, V_STAT[k], "R2/R7/R10");
      chk_reg(3'd4, V_SEC[k], "R8");
      chk_irq(V_IRQ[k], "R10");
    end
    @(negedge clk); top_src = '0; sec_src = '0;
    wr(3'd1, 32'h0); wr(3'd5, 32'h0);
    wait_n(4);

    // R3 edge latch persists
    @(negedge clk); top_src = 32'h0002_0000;
    wait_n(4);
    chk_reg(3'd2, 32'h0002_0000, "R3");
    top_src = '0;
    wait_n(4);
    chk_reg(3'd0, 32'h0002_0000, "R3");
    wr(3'd1, 32'h0002_0000);
    chk_irq(1'b1, "R10");

    // R4 write ones keeps, zeros clear
    wr(3'd2, 32'hFFFF_FFFF);
    chk_reg(3'd2, 32'h0002_0000, "R4");
    wr(3'd2, 32'h0);
    chk_reg(3'd2, 32'h0, "R4");
    chk_irq(1'b0, "R4");

    // R5 edge and clear on the same edge
    @(negedge clk); top_src = 32'h0040_0000;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd2; wdata = 32'h0;
    @(negedge clk); we = 1'b0;
    chk_reg(3'd2, 32'h0040_0000, "R5");
    top_src = '0;
    wait_n(4);
    wr(3'd2, 32'h0);

    // R6 software bit
    wr(3'd3, 32'h1000_0000);
    @(negedge clk);
    chk_reg(3'd3, 32'h1000_0000, "R6");
    chk_reg(3'd0, 32'h1000_0000, "R6");
    wr(3'd2, 32'h0);
    chk_reg(3'd0, 32'h0, "R6");
    wr(3'd3, 32'h0);

    // R9 secondary edge, R7 summary through it
    wr(3'd5, 32'h0040_0000);
    @(negedge clk); sec_src = 32'h0040_0000;
    wait_n(4);
    sec_src = '0;
    wait_n(4);
    chk_reg(3'd4, 32'h0040_0000, "R9");
    chk_reg(3'd0, 32'h0000_0010, "R7");
    wr(3'd4, 32'hFFFF_FFFF);
    chk_reg(3'd4, 32'h0040_0000, "R9");
    wr(3'd4, 32'h0);
    chk_reg(3'd4, 32'h0, "R9");
    chk_reg(3'd0, 32'h0, "R9");

    // R11 unused addresses
    chk_reg(3'd6, 32'h0, "R11");
    chk_reg(3'd7, 32'h0, "R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule